// File: doc/BRIEF.md
# Addressed I2C Slave with Pointer-Based Register File

This block is an I2C target that lets an external host read and write a small bank of byte-wide registers. It is clocked from a fast system clock. SCL and SDA are first passed through synchronizer flops, and bus events are detected from the synchronized levels. The block never drives SDA high. It only asserts an output enable that pulls the line low, and an external pull-up supplies the high level.

The block responds only to its fixed 7-bit device address. In a write transfer, the first byte after the address sets an internal register pointer. Each later byte is stored at the pointed register, and the pointer then advances. A read transfer, usually reached through a repeated START after a pointer load, returns bytes beginning at the current pointer, and the pointer advances after each byte. A STOP ends the transfer at whatever bit it arrives.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The device address is 7'b1001101 followed by the R/W bit, so the address byte is 0x9A for write and 0x9B for read. On a match the slave pulls SDA low in the ninth clock. On a mismatch SDA stays released for that byte and for every later byte until the next START or STOP, and no register changes.
- R2: In a write transfer the slave holds SDA low for the whole ninth SCL high phase of every byte it receives.
- R3: The first byte after a write address loads the register pointer (taken modulo the register count). That byte is not stored in any register.
- R4: Each further write byte is stored in the register at the pointer, and the pointer then advances by one.
- R5: The pointer wraps from the last register (7 by default) to register 0, for both writes and reads.
- R6: A read returns the register at the pointer, MSB first, one bit per SCL clock. The pointer advances after each byte. A master acknowledge (SDA low in the ninth clock) continues the read with the next register, and a later read address without a pointer load continues from where the pointer stands.
- R7: After a master not-acknowledge (SDA high in the ninth clock), the slave does not drive SDA again until a new START.
- R8: A repeated START at any point restarts the address phase, and the pointer keeps its value across it.
- R9: A STOP at any bit position releases SDA and ends the transfer. A partly received byte is discarded.
- R10: After reset SDA is released, every register reads 0x00 and the pointer is 0.
- R11: The slave asserts its SDA output enable only while SCL is low. The enable is therefore constant during every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |

## Verification
A corrupted state or bit counter shows up in the first following acknowledge slot. The host sees a missing ACK, or an ACK one bit early, within the same byte. A pointer that loads or advances wrongly is invisible during a write. It appears on the first read-back, as data from the wrong register. A STOP or repeated START that fails to clear the state shows up on the next address byte, either as a lost acknowledge or as a register written by a byte that should have been discarded.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_CW = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_SKIP
   } slv_state_e;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_rf_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_d;
   logic              sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s    = scl_pipe[STAGES-1];
   assign sda_s    = sda_pipe[STAGES-1];
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs #(
   parameter int NREGS = 8,
   parameter int W     = 8,
   localparam int PW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ptr_load,
   input  logic [W-1:0]  load_val,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          ptr_inc,
   output logic [W-1:0]  rd_data
);
   generate
      if (NREGS < 2) begin : g_bad_nregs
         $error("i2c_rf_regs: NREGS must be at least 2");
      end
      if (PW > W) begin : g_bad_width
         $error("i2c_rf_regs: pointer wider than a byte");
      end
   endgenerate

   logic [W-1:0]  mem_q [NREGS];
   logic [PW-1:0] ptr_q;
   logic [PW-1:0] ptr_next_inc;
   logic [PW-1:0] ptr_loaded;

   assign ptr_loaded = PW'(load_val % NREGS);

   generate
      if ((1 << PW) == NREGS) begin : g_wrap_pow2
         assign ptr_next_inc = ptr_q + PW'(1);
      end else begin : g_wrap_cmp
         assign ptr_next_inc = (ptr_q == PW'(NREGS - 1)) ? '0 : ptr_q + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
      end else begin
         if (wr_en) mem_q[ptr_q] <= wr_data;
         if (ptr_load)     ptr_q <= ptr_loaded;
         else if (ptr_inc) ptr_q <= ptr_next_inc;
      end
   end

   assign rd_data = mem_q[ptr_q];

   // R5
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_inc && !ptr_load) |=>
         ptr_q == (($past(ptr_q) == PW'(NREGS - 1)) ? '0 : PW'($past(ptr_q) + PW'(1))));

   // R4
   wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem_q[$past(ptr_q)] == $past(wr_data));
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
   import i2c_rf_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b1001101,
   parameter int         NREGS       = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o
);
   logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

   i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p)
   );

   slv_state_e         state_q;
   logic [BIT_CW-1:0]  bit_cnt_q;
   logic [BYTE_W-1:0]  rx_q;
   logic [BYTE_W-1:0]  tx_q;
   logic               rw_q;
   logic               first_q;
   logic               mack_q;
   logic               oe_q;
   logic [BYTE_W-1:0]  rd_data;
   logic               byte_end;
   logic               ptr_load;
   logic               wr_en;
   logic               ptr_inc;

   assign byte_end = scl_fall && (bit_cnt_q == BIT_CW'(BYTE_W));
   assign ptr_load = (state_q == ST_WR) && byte_end && first_q && !start_p && !stop_p;
   assign wr_en    = (state_q == ST_WR) && byte_end && !first_q && !start_p && !stop_p;
   assign ptr_inc  = wr_en || ((state_q == ST_RD) && byte_end && !start_p && !stop_p);

   i2c_rf_regs #(.NREGS(NREGS), .W(BYTE_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ptr_load (ptr_load),
      .load_val (rx_q),
      .wr_en    (wr_en),
      .wr_data  (rx_q),
      .ptr_inc  (ptr_inc),
      .rd_data  (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bit_cnt_q <= '0;
         rx_q      <= '0;
         tx_q      <= '0;
         rw_q      <= 1'b0;
         first_q   <= 1'b0;
         mack_q    <= 1'b0;
         oe_q      <= 1'b0;
      end else if (stop_p) begin
         state_q   <= ST_IDLE;
         bit_cnt_q <= '0;
         oe_q      <= 1'b0;
      end else if (start_p) begin
         state_q   <= ST_ADDR;
         bit_cnt_q <= '0;
         oe_q      <= 1'b0;
      end else begin
         case (state_q)
            ST_ADDR: begin
               if (scl_rise) begin
                  rx_q      <= {rx_q[BYTE_W-2:0], sda_s};
                  bit_cnt_q <= bit_cnt_q + BIT_CW'(1);
               end else if (byte_end) begin
                  if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
                     state_q <= ST_ADDR_ACK;
                     rw_q    <= rx_q[0];
                     oe_q    <= 1'b1;
                  end else begin
                     state_q <= ST_SKIP;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  bit_cnt_q <= '0;
                  if (rw_q) begin
                     state_q <= ST_RD;
                     tx_q    <= rd_data;
                     oe_q    <= ~rd_data[BYTE_W-1];
                  end else begin
                     state_q <= ST_WR;
                     first_q <= 1'b1;
                     oe_q    <= 1'b0;
                  end
               end
            end
            ST_WR: begin
               if (scl_rise) begin
                  rx_q      <= {rx_q[BYTE_W-2:0], sda_s};
                  bit_cnt_q <= bit_cnt_q + BIT_CW'(1);
               end else if (byte_end) begin
                  state_q <= ST_WR_ACK;
                  first_q <= 1'b0;
                  oe_q    <= 1'b1;
               end
            end
            ST_WR_ACK: begin
               if (scl_fall) begin
                  state_q   <= ST_WR;
                  bit_cnt_q <= '0;
                  oe_q      <= 1'b0;
               end
            end
            ST_RD: begin
               if (scl_rise) begin
                  bit_cnt_q <= bit_cnt_q + BIT_CW'(1);
               end else if (byte_end) begin
                  state_q <= ST_RD_ACK;
                  oe_q    <= 1'b0;
               end else if (scl_fall) begin
                  tx_q <= tx_q << 1;
                  oe_q <= ~tx_q[BYTE_W-2];
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) begin
                  mack_q <= ~sda_s;
               end else if (scl_fall) begin
                  if (mack_q) begin
                     state_q   <= ST_RD;
                     bit_cnt_q <= '0;
                     tx_q      <= rd_data;
                     oe_q      <= ~rd_data[BYTE_W-1];
                  end else begin
                     state_q <= ST_SKIP;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = oe_q;

   // R11
   oe_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !scl_s);

   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> (!oe_q && state_q == ST_IDLE));

   // R1
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP) |-> !oe_q);

   // R2
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADDR_ACK || state_q == ST_WR_ACK) |-> oe_q);
endmodule

// File: tb/tb_i2c_regfile_slave.sv
module tb_i2c_regfile_slave;
   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   wire  sda_line = sda_m & ~sda_oe;

   int checks = 0;
   int fails  = 0;
   int glitch = 0;
   logic [7:0] model [8];
   logic [7:0] rbuf  [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_regfile_slave dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .sda_oe_o (sda_oe)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic q();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic bit_cycle(input logic drv, output logic seen);
      logic oe_a;
      sda_m = drv; q();
      scl_m = 1'b1; q();
      seen = sda_line; oe_a = sda_oe; q();
      if (sda_oe !== oe_a) glitch++;
      scl_m = 1'b0; q();
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; q();
      scl_m = 1'b1; q();
      sda_m = 1'b0; q();
      scl_m = 1'b0; q();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; q();
      scl_m = 1'b1; q();
      sda_m = 1'b1; q();
   endtask

   task automatic write_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
      bit_cycle(1'b1, s);
      ack = ~s;
   endtask

   task automatic read_byte(input logic mack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_cycle(1'b1, s);
         d[i] = s;
      end
      bit_cycle(~mack, s);
   endtask

   task automatic write_regs(input logic [7:0] ptr, input int n, input logic [7:0] base, input string tag);
      logic a;
      i2c_start();
      write_byte(8'h9A, a); chk(a, "R1 write addr ack", a, 1);
      write_byte(ptr, a);   chk(a, {tag, " ptr ack"}, a, 1);
      for (int k = 0; k < n; k++) begin
         write_byte(base + 8'(k), a);
         chk(a, {tag, " data ack R2"}, a, 1);
         model[(ptr + k) % 8] = base + 8'(k);
      end
      i2c_stop();
   endtask

   task automatic read_from(input logic [7:0] ptr, input int n, input string tag);
      logic a;
      i2c_start();
      write_byte(8'h9A, a); chk(a, "R1 addr ack", a, 1);
      write_byte(ptr, a);   chk(a, "R3 ptr ack", a, 1);
      i2c_start();
      write_byte(8'h9B, a); chk(a, "R8 read addr ack", a, 1);
      for (int k = 0; k < n; k++) begin
         read_byte(k < n - 1, rbuf[k]);
         chk(rbuf[k] == model[(ptr + k) % 8], tag, rbuf[k], model[(ptr + k) % 8]);
      end
      i2c_stop();
   endtask

   task automatic t_reset();
      chk(sda_oe == 1'b0, "R10 oe after reset", sda_oe, 0);
      read_from(8'd0, 8, "R10 reset value");
   endtask

   task automatic t_write_burst();
      write_regs(8'd2, 3, 8'h11, "R4");
      read_from(8'd0, 5, "R3/R4 readback");
   endtask

   task automatic t_wrap();
      write_regs(8'd7, 2, 8'hA7, "R5");
      read_from(8'd6, 4, "R5 wrap read");
   endtask

   task automatic t_read_continue();
      logic a;
      logic [7:0] d;
      read_from(8'd3, 2, "R6 read");
      i2c_start();
      write_byte(8'h9B, a); chk(a, "R6 read addr ack", a, 1);
      read_byte(1'b0, d);
      chk(d == model[5], "R6 continue from pointer", d, model[5]);
   endtask

   task automatic t_nack_release();
      logic s;
      int low = 0;
      for (int k = 0; k < 9; k++) begin
         bit_cycle(1'b1, s);
         if (!s) low++;
      end
      chk(low == 0, "R7 no drive after nack", low, 0);
      i2c_stop();
   endtask

   task automatic t_mismatch();
      logic a;
      i2c_start();
      write_byte(8'h5A, a); chk(!a, "R1 wrong addr nack", a, 0);
      write_byte(8'h01, a); chk(!a, "R1 ignored byte nack", a, 0);
      write_byte(8'hEE, a); chk(!a, "R1 ignored byte2 nack", a, 0);
      i2c_stop();
      i2c_start();
      write_byte(8'h9C, a); chk(!a, "R1 near addr nack", a, 0);
      write_byte(8'h00, a); chk(!a, "R1 ignored nack", a, 0);
      i2c_stop();
      read_from(8'd0, 8, "R1 regs unchanged");
   endtask

   task automatic t_stop_mid();
      logic a, s;
      i2c_start();
      write_byte(8'h9A, a); chk(a, "R9 addr ack", a, 1);
      write_byte(8'h03, a); chk(a, "R9 ptr ack", a, 1);
      for (int k = 0; k < 3; k++) bit_cycle(1'b0, s);
      i2c_stop();
      chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
      i2c_start();
      for (int k = 0; k < 4; k++) bit_cycle(1'b1, s);
      i2c_stop();
      read_from(8'd3, 1, "R9 partial byte dropped");
      i2c_start();
      write_byte(8'h9A, a); chk(a, "R9 ack after stop", a, 1);
      write_byte(8'h01, a);
      write_byte(8'h5C, a); chk(a, "R9 data ack", a, 1);
      model[1] = 8'h5C;
      write_byte(8'h00, a);
      i2c_stop();
      model[2] = 8'h00;
      read_from(8'd1, 2, "R9 transfer after stop");
   endtask

   task automatic t_rstart_mid();
      logic a, s;
      i2c_start();
      write_byte(8'h9A, a);
      write_byte(8'h06, a);
      for (int k = 0; k < 5; k++) bit_cycle(1'b1, s);
      i2c_start();
      write_byte(8'h9B, a); chk(a, "R8 rstart mid byte ack", a, 1);
      read_byte(1'b0, rbuf[0]);
      chk(rbuf[0] == model[6], "R8 pointer kept", rbuf[0], model[6]);
      i2c_stop();
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) model[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write_burst();
      t_wrap();
      t_read_continue();
      t_nack_release();
      t_mismatch();
      t_stop_mid();
      t_rstart_mid();
      chk(glitch == 0, "R11 oe stable while SCL high", glitch, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule